// File: doc/BRIEF.md
# Memory Contention Interference Accountant

This unit sits beside one core and measures how many cycles that core loses because other cores occupy the shared DRAM path. It watches the core's outstanding memory request. It also watches the controller's report of who holds the memory bus and who holds the targeted bank, and which row is open in that bank. Waiting cycles caused by another core's bus or bank occupancy are added to two cycle counters. A row that this core opened but that another core has since replaced is charged, once per request, as a precharge-plus-activate penalty in a third counter. A small per-bank table holds the row most recently activated by this core alone, and the row check uses it.

All accounting is gated. Nothing accumulates unless the reorder buffer is full and its head is blocked on a miss, so overlapped misses are never charged. The counters saturate. Each one can be cleared on its own by a host through a three-bit clear input, and it is read directly from the outputs.

A two-state controller tracks the request. `ST_IDLE` means no request is pending. `ST_WAIT` means a request is outstanding. Transition ARRIVE (`ST_IDLE` to `ST_WAIT`) fires when `req_valid` is seen high, and the row check is done on that arrival cycle only. Transition RETIRE (`ST_WAIT` to `ST_IDLE`) fires when `req_valid` falls.

Top module: `mem_interf_acct`

## Requirements
- R1: After reset all three counters read zero and the open-row table holds no valid entry.
- R2: Each clock edge at which `req_valid`, the accounting gate and `bus_busy` are high and `bus_owner` differs from the parameter `SELF_ID` adds one to `bus_cycles`.
- R3: Bus or bank occupancy whose owner equals `SELF_ID` adds nothing to `bus_cycles` or `bank_cycles`.
- R4: Each clock edge at which `req_valid`, the gate and `bank_busy` are high and `bank_owner` differs from `SELF_ID` adds one to `bank_cycles`.
- R5: When `act_valid` is high, the table entry for `act_bank` becomes `act_row`. A later activation by this core in the same bank replaces it.
- R6: On the ARRIVE edge with the gate high, `row_cycles` grows by `T_PRE + T_ACT` if three conditions hold: `row_open_valid` is high, `open_row` differs from `req_row`, and the table entry for `req_bank` is valid and equals `req_row`.
- R7: No row charge is made when the needed row is already open, or when the table entry for that bank differs from `req_row`.
- R8: While `rob_full` and `rob_head_miss` are not both high, no counter changes except by clearing.
- R9: Each counter saturates at 2^CNT_W-1 and never wraps.
- R10: Bit 0, 1 and 2 of `clr` zero `bus_cycles`, `bank_cycles` and `row_cycles` respectively at the next edge. Clearing overrides an increment in the same cycle and leaves the other counters alone.
- R11: A request is row-checked only once. While in `ST_WAIT`, `row_cycles` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core has a memory request ready |
| req_bank | input | BANK_W | Bank targeted by the request |
| req_row | input | ROW_W | Row needed by the request |
| bus_busy | input | 1 | Memory bus occupied |
| bus_owner | input | CORE_W | Core holding the bus |
| bank_busy | input | 1 | Targeted bank occupied |
| bank_owner | input | CORE_W | Core holding the targeted bank |
| row_open_valid | input | 1 | A row is open in the targeted bank |
| open_row | input | ROW_W | Row currently open in the targeted bank |
| act_valid | input | 1 | This core's access activates a row |
| act_bank | input | BANK_W | Bank of that activation |
| act_row | input | ROW_W | Row of that activation |
| rob_full | input | 1 | Reorder buffer full |
| rob_head_miss | input | 1 | Reorder buffer head blocked on a miss |
| clr | input | 3 | Per-counter clear: bit0 bus, bit1 bank, bit2 row |
| bus_cycles | output | CNT_W | Bus interference cycles |
| bank_cycles | output | CNT_W | Bank interference cycles |
| row_cycles | output | CNT_W | Row conflict cycles |

## Verification
Several properties are checked on every cycle. Counters never go backwards except through a clear, and a clear always lands on zero. The bus and bank counters move by at most one per edge. No counter moves while the gate is off, and the row counter is frozen while a request sits in `ST_WAIT`. The directed scenarios show the things a cycle-local property cannot pin down. These are the exact counts for runs of foreign-owned bus and bank cycles, self-owned occupancy being ignored, the table-driven row decision across activations that replace a bank's entry, saturation at the counter limit, and clear winning over a same-cycle increment.

// File: rtl/mia_pkg.sv
package mia_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } req_state_e;
endpackage

// File: rtl/mia_sat_counter.sv
module mia_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_val,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W:0] sum;

    assign sum = {1'b0, cnt} + {1'b0, add_val};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (add_en) begin
            cnt <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        end
    end

    // Counter only moves upward unless cleared (no wrap)
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));

    // A clear always lands on zero
    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
endmodule

// File: rtl/mia_open_row_table.sv
module mia_open_row_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [BANK_W-1:0] rd_bank,
    output logic              rd_valid,
    output logic [ROW_W-1:0]  rd_row
);
    localparam int NBANK = 1 << BANK_W;

    logic [ROW_W-1:0] row_q [NBANK];
    logic [NBANK-1:0] vld_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[b] <= 1'b0;
                row_q[b] <= '0;
            end else if (wr_en && wr_bank == BANK_W'(b)) begin
                vld_q[b] <= 1'b1;
                row_q[b] <= wr_row;
            end
        end
    end

    assign rd_valid = vld_q[rd_bank];
    assign rd_row   = row_q[rd_bank];

    // A write always leaves its entry valid with the written row
    assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_bank)] && row_q[$past(wr_bank)] == $past(wr_row));
endmodule

// File: rtl/mem_interf_acct.sv
module mem_interf_acct #(
    parameter int CORE_W  = 2,
    parameter int SELF_ID = 1,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 8,
    parameter int CNT_W   = 16,
    parameter int T_PRE   = 3,
    parameter int T_ACT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              bus_busy,
    input  logic [CORE_W-1:0] bus_owner,
    input  logic              bank_busy,
    input  logic [CORE_W-1:0] bank_owner,
    input  logic              row_open_valid,
    input  logic [ROW_W-1:0]  open_row,
    input  logic              act_valid,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              rob_full,
    input  logic              rob_head_miss,
    input  logic [2:0]        clr,
    output logic [CNT_W-1:0]  bus_cycles,
    output logic [CNT_W-1:0]  bank_cycles,
    output logic [CNT_W-1:0]  row_cycles
);
    import mia_pkg::*;

    localparam logic [CORE_W-1:0] ME       = CORE_W'(SELF_ID);
    localparam logic [CNT_W-1:0]  ROW_COST = CNT_W'(T_PRE + T_ACT);
    localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

    req_state_e state_q, state_d;

    logic             gate;
    logic             ora_valid;
    logic [ROW_W-1:0] ora_row;
    logic             row_stolen;
    logic             bus_inc, bank_inc, row_add;

    assign gate = rob_full && rob_head_miss;

    mia_open_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_ora (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (act_valid),
        .wr_bank  (act_bank),
        .wr_row   (act_row),
        .rd_bank  (req_bank),
        .rd_valid (ora_valid),
        .rd_row   (ora_row)
    );

    // Needed row was this core's, yet a different row is open now
    assign row_stolen = row_open_valid && (open_row != req_row)
                        && ora_valid && (ora_row == req_row);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        row_add  = 1'b0;
        bus_inc  = req_valid && gate && bus_busy  && (bus_owner  != ME);
        bank_inc = req_valid && gate && bank_busy && (bank_owner != ME);
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    row_add = gate && row_stolen;
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!req_valid) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    mia_sat_counter #(.CNT_W(CNT_W)) u_bus_ctr (
        .clk(clk), .rst_n(rst_n), .clr(clr[0]),
        .add_en(bus_inc), .add_val(ONE), .cnt(bus_cycles)
    );

    mia_sat_counter #(.CNT_W(CNT_W)) u_bank_ctr (
        .clk(clk), .rst_n(rst_n), .clr(clr[1]),
        .add_en(bank_inc), .add_val(ONE), .cnt(bank_cycles)
    );

    mia_sat_counter #(.CNT_W(CNT_W)) u_row_ctr (
        .clk(clk), .rst_n(rst_n), .clr(clr[2]),
        .add_en(row_add), .add_val(ROW_COST), .cnt(row_cycles)
    );

    // Gate off: counters hold unless cleared
    assert_gate_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !clr[0]) |=> $stable(bus_cycles));
    assert_gate_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !clr[1]) |=> $stable(bank_cycles));
    assert_gate_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !clr[2]) |=> $stable(row_cycles));

    // Bus and bank counters step by at most one per edge
    assert_bus_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr[0] |=> (bus_cycles - $past(bus_cycles)) <= ONE);
    assert_bank_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr[1] |=> (bank_cycles - $past(bank_cycles)) <= ONE);

    // Row check happens only on arrival
    assert_row_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !clr[2]) |=> $stable(row_cycles));
endmodule

// File: tb/mem_interf_acct_bench.sv
module mem_interf_acct_bench;
    localparam int CW = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [1:0] req_bank;
    logic [7:0] req_row;
    logic       bus_busy;
    logic [1:0] bus_owner;
    logic       bank_busy;
    logic [1:0] bank_owner;
    logic       row_open_valid;
    logic [7:0] open_row;
    logic       act_valid;
    logic [1:0] act_bank;
    logic [7:0] act_row;
    logic       rob_full;
    logic       rob_head_miss;
    logic [2:0] clr;
    logic [CW-1:0] bus_cycles, bank_cycles, row_cycles;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mem_interf_acct #(.CNT_W(CW)) u_mem_interf_acct (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
        .bus_busy(bus_busy), .bus_owner(bus_owner),
        .bank_busy(bank_busy), .bank_owner(bank_owner),
        .row_open_valid(row_open_valid), .open_row(open_row),
        .act_valid(act_valid), .act_bank(act_bank), .act_row(act_row),
        .rob_full(rob_full), .rob_head_miss(rob_head_miss), .clr(clr),
        .bus_cycles(bus_cycles), .bank_cycles(bank_cycles), .row_cycles(row_cycles)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        req_valid = 0; req_bank = 0; req_row = 0;
        bus_busy = 0; bus_owner = 0; bank_busy = 0; bank_owner = 0;
        row_open_valid = 0; open_row = 0;
        act_valid = 0; act_bank = 0; act_row = 0;
        rob_full = 0; rob_head_miss = 0; clr = 0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 0; quiet();
        step(3);
        rst_n = 1;
        step(1);
        chk("R1 bus", bus_cycles, 0);
        chk("R1 bank", bank_cycles, 0);
        chk("R1 row", row_cycles, 0);
        // Empty table: stolen-looking request charges nothing
        req_valid = 1; req_bank = 0; req_row = 8'h05;
        row_open_valid = 1; open_row = 8'h06; rob_full = 1; rob_head_miss = 1;
        step(1); quiet(); step(1);
        chk("R1 table empty", row_cycles, 0);
    endtask

    task automatic t_bus();
        req_valid = 1; rob_full = 1; rob_head_miss = 1;
        bus_busy = 1; bus_owner = 2;
        step(5);
        quiet(); step(1);
        chk("R2 bus foreign", bus_cycles, 5);
        req_valid = 1; rob_full = 1; rob_head_miss = 1;
        bus_busy = 1; bus_owner = 1; bank_busy = 1; bank_owner = 1;
        step(4);
        quiet(); step(1);
        chk("R3 bus self", bus_cycles, 5);
        chk("R3 bank self", bank_cycles, 0);
        clr = 3'b001; step(1); clr = 0;
        chk("R10 bus cleared", bus_cycles, 0);
    endtask

    task automatic t_bank();
        req_valid = 1; rob_full = 1; rob_head_miss = 1;
        bank_busy = 1; bank_owner = 3; req_bank = 2;
        step(6);
        quiet(); step(1);
        chk("R4 bank foreign", bank_cycles, 6);
        chk("R4 bus untouched", bus_cycles, 0);
    endtask

    task automatic t_gate();
        req_valid = 1; rob_full = 1; rob_head_miss = 0;
        bus_busy = 1; bus_owner = 0; bank_busy = 1; bank_owner = 2;
        step(4);
        rob_full = 0; rob_head_miss = 1;
        step(4);
        quiet(); step(1);
        chk("R8 bus gated", bus_cycles, 0);
        chk("R8 bank gated", bank_cycles, 6);
        // Row check with gate off
        act_valid = 1; act_bank = 1; act_row = 8'h70; step(1); act_valid = 0;
        req_valid = 1; req_bank = 1; req_row = 8'h70;
        row_open_valid = 1; open_row = 8'h71; rob_full = 1;
        step(1); quiet(); step(1);
        chk("R8 row gated", row_cycles, 0);
    endtask

    task automatic t_row();
        act_valid = 1; act_bank = 2; act_row = 8'h11;
        step(1); act_valid = 0;
        req_valid = 1; req_bank = 2; req_row = 8'h11;
        row_open_valid = 1; open_row = 8'h22; rob_full = 1; rob_head_miss = 1;
        step(1);
        chk("R6 row charge", row_cycles, 7);
        step(5);
        chk("R11 no recharge", row_cycles, 7);
        req_valid = 0; step(1);
        req_valid = 1; req_row = 8'h33; step(1);
        req_valid = 0; step(1);
        chk("R7 table mismatch", row_cycles, 7);
        req_valid = 1; req_row = 8'h11; open_row = 8'h11; step(1);
        req_valid = 0; step(1);
        chk("R7 row already open", row_cycles, 7);
        quiet();
        act_valid = 1; act_bank = 2; act_row = 8'h44; step(1); act_valid = 0;
        req_valid = 1; req_bank = 2; req_row = 8'h11;
        row_open_valid = 1; open_row = 8'h22; rob_full = 1; rob_head_miss = 1;
        step(1); req_valid = 0; step(1);
        chk("R5 entry replaced", row_cycles, 7);
        req_valid = 1; req_row = 8'h44; step(1); req_valid = 0; step(1);
        chk("R5 new entry charges", row_cycles, 14);
        quiet(); step(1);
    endtask

    task automatic t_sat();
        req_valid = 1; rob_full = 1; rob_head_miss = 1;
        bus_busy = 1; bus_owner = 3;
        step(70);
        chk("R9 bus saturated", bus_cycles, 63);
        step(2);
        chk("R9 bus held", bus_cycles, 63);
        quiet(); step(1);
        // Row counter: repeated charges of 7 from 14
        act_valid = 1; act_bank = 3; act_row = 8'h01; step(1); act_valid = 0;
        for (int k = 0; k < 8; k++) begin
            req_valid = 1; req_bank = 3; req_row = 8'h01;
            row_open_valid = 1; open_row = 8'h02; rob_full = 1; rob_head_miss = 1;
            step(1); req_valid = 0; step(1);
        end
        chk("R9 row saturated", row_cycles, 63);
        quiet(); step(1);
    endtask

    task automatic t_clear();
        req_valid = 1; rob_full = 1; rob_head_miss = 1;
        bus_busy = 1; bus_owner = 2; bank_busy = 1; bank_owner = 0;
        clr = 3'b001;
        step(1);
        chk("R10 clear beats inc", bus_cycles, 0);
        chk("R10 bank kept", bank_cycles, 7);
        chk("R10 row kept", row_cycles, 63);
        quiet();
        clr = 3'b110; step(1); clr = 0;
        chk("R10 bank cleared", bank_cycles, 0);
        chk("R10 row cleared", row_cycles, 0);
    endtask

    initial begin
        t_reset();
        t_bus();
        t_bank();
        t_gate();
        t_row();
        t_sat();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule